// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block drives the direction (driver-enable) pin of an RS-485 line transceiver from the state of a UART transmitter. It asserts the enable as soon as the transmitter has anything to send, that is, when the transmit FIFO is not empty or the shift register is still shifting. It keeps the enable asserted for as long as that condition lasts.

Once both the FIFO and the shift register have gone idle, the final stop bit has left the line. The block then keeps the driver enabled for a further, programmable number of bit periods and releases it afterwards. One bit period is 16 pulses of the 16x oversample baud enable. The hold length is an 8-bit count of whole bit periods, from 0 to 255, and it is captured at the moment the hold begins. If new data arrives while the hold is running, the hold is abandoned and the enable stays on without a gap.

A polarity input chooses whether the asserted level of the pin is low or high. The FIFO, transmitter, baud divisor and register access sit outside this block and are seen only as inputs.

Top module: `txdir_ctrl`

## Requirements
- R1: While reset is applied and after it is released with no transmit activity, `dir_o` sits at the deasserted level for the current polarity: 1 when `pol_inv_i`=0 and 0 when `pol_inv_i`=1.
- R2: Transmit activity means `txf_empty_i`=0 or `txsr_busy_i`=1. When activity is present at a rising clock edge, the enable is asserted from that edge onward.
- R3: When activity ends and the captured hold value D is nonzero, the enable stays asserted until the clock edge at which the 16*D-th `os_tick_i` pulse sampled since the hold began arrives. It is deasserted from that edge on.
- R4: With a hold value of 0, the enable is deasserted at the first clock edge that samples no activity. That is the cycle after the stop bit completes.
- R5: The largest hold value, 255, gives a hold of 4080 oversample ticks.
- R6: Activity that returns during a hold cancels the hold, and the enable stays asserted on every cycle in between. The next hold then restarts with its full length.
- R7: The hold value is captured at the edge where the hold starts. Changes to `hold_bits_i` during a hold have no effect on that hold.
- R8: Asserted level: `dir_o`=0 when `pol_inv_i`=0 and `dir_o`=1 when `pol_inv_i`=1. A change of `pol_inv_i` shows on `dir_o` at once, without a clock edge.
- R9: Oversample ticks that arrive while activity is still present, or at the edge where the hold starts, do not count toward the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| txf_empty_i | input | 1 | Transmit FIFO empty flag |
| txsr_busy_i | input | 1 | Transmit shift register busy, high up to the end of the stop bit |
| os_tick_i | input | 1 | Single-cycle 16x oversample baud enable |
| hold_bits_i | input | 8 | Hold length in bit periods, 0 to 255 |
| pol_inv_i | input | 1 | Polarity select: 1 gives an active-high direction pin |
| dir_o | output | 1 | Direction control to the line driver |

## Verification
The assertions assume that `os_tick_i` is a single-cycle strobe. They also assume that the activity flags are synchronous to `clk` and stable between edges. None of them expects the hold value or the flags to stay fixed across a hold. The stimulus drives every input only on the falling edge. It draws ticks with a random spacing, including back-to-back ticks, and makes the activity flags toggle at random during holds so that cancellations happen often. It also changes `hold_bits_i` and `pol_inv_i` in the middle of holds, so the captured value and the immediate polarity path are both exercised.

// File: rtl/txdir_pkg.sv
package txdir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } dir_state_e;
endpackage

// File: rtl/txdir_subtick.sv
// Counts oversample ticks during a hold and strobes once per bit period.
module txdir_subtick #(
  parameter int OS_RATIO = 16,
  localparam int SUB_W = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_stb_o
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OS_RATIO - 1);

  logic [SUB_W-1:0] sub_q, sub_d;
  logic             sub_en;
  logic             at_last;

  assign at_last   = (sub_q == SUB_LAST);
  assign bit_stb_o = run_i & tick_i & at_last & ~clr_i;
  assign sub_en    = clr_i | (run_i & tick_i);

  always_comb begin
    sub_d = sub_q;
    if (clr_i) begin
      sub_d = '0;
    end else if (run_i && tick_i) begin
      sub_d = at_last ? '0 : sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (sub_en) begin
      sub_q <= sub_d;
    end
  end

  // R3: two bit strobes are always at least one full bit period apart
  assert_stb_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |=> !bit_stb_o);

  // R9: with no tick and no clear the phase does not move
  assert_idle_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(sub_q));
endmodule

// File: rtl/txdir_holdcnt.sv
// Remaining hold length in bit periods, captured at the start of a hold.
module txdir_holdcnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | dec_i;
  assign last_o = (cnt_q == DLY_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R7: outside a capture or a bit strobe the remaining length is frozen
  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !dec_i) |=> $stable(cnt_q));

  // R3: a bit strobe never arrives with nothing left to count
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/txdir_fsm.sv
// Idle / sending / holding sequencer for the driver enable.
module txdir_fsm
  import txdir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic hold_zero_i,
  input  logic bit_stb_i,
  input  logic hold_last_i,
  output logic load_o,
  output logic in_hold_o,
  output logic en_o
);
  dir_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (active_i) state_d = ST_SEND;
      end
      ST_SEND: begin
        if (!active_i) begin
          if (hold_zero_i) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_HOLD;
            load_o  = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (active_i) begin
          state_d = ST_SEND;
        end else if (bit_stb_i && hold_last_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign in_hold_o = (state_q == ST_HOLD);
  assign en_o      = (state_q != ST_IDLE);

  // R2: activity at an edge means the enable is on after it
  assert_assert_on_activity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> en_o);

  // R6: a running enable never drops while activity is present
  assert_no_glitch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && active_i) |=> (en_o && !in_hold_o));

  // R4: zero hold releases on the first idle edge
  assert_zero_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && !in_hold_o && !active_i && hold_zero_i) |=> !en_o);

  // R3: a hold ends only on a bit strobe
  assert_hold_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold_o && !active_i && !bit_stb_i) |=> in_hold_o);
endmodule

// File: rtl/txdir_ctrl.sv
// RS-485 driver-enable control: top level.
module txdir_ctrl #(
  parameter int DLY_W    = 8,
  parameter int OS_RATIO = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txf_empty_i,
  input  logic             txsr_busy_i,
  input  logic             os_tick_i,
  input  logic [DLY_W-1:0] hold_bits_i,
  input  logic             pol_inv_i,
  output logic             dir_o
);
  logic active;
  logic hold_zero;
  logic load;
  logic in_hold;
  logic en;
  logic bit_stb;
  logic hold_last;

  assign active    = ~txf_empty_i | txsr_busy_i;
  assign hold_zero = (hold_bits_i == '0);

  txdir_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .hold_zero_i (hold_zero),
    .bit_stb_i   (bit_stb),
    .hold_last_i (hold_last),
    .load_o      (load),
    .in_hold_o   (in_hold),
    .en_o        (en)
  );

  txdir_subtick #(.OS_RATIO(OS_RATIO)) u_subtick (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (load),
    .run_i     (in_hold),
    .tick_i    (os_tick_i),
    .bit_stb_o (bit_stb)
  );

  txdir_holdcnt #(.DLY_W(DLY_W)) u_holdcnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (hold_bits_i),
    .dec_i      (bit_stb),
    .last_o     (hold_last)
  );

  // Asserted level follows the polarity select: low normally, high when inverted.
  assign dir_o = pol_inv_i ? en : ~en;

  // R1: straight after reset the enable is off
  assert_reset_off_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !en);
endmodule

// File: tb/tb_txdir_ctrl.sv
module tb_txdir_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       txf_empty_i;
  logic       txsr_busy_i;
  logic       os_tick_i;
  logic [7:0] hold_bits_i;
  logic       pol_inv_i;
  logic       dir_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  string tag = "R1";

  // bench reference model: phase 0 idle, 1 send, 2 hold; ticks left in hold
  int  m_phase = 0;
  int  m_left = 0;
  bit  m_en = 1'b0;

  always #4 clk = ~clk;

  txdir_ctrl dut (
    .clk(clk), .rst_n(rst_n), .txf_empty_i(txf_empty_i), .txsr_busy_i(txsr_busy_i),
    .os_tick_i(os_tick_i), .hold_bits_i(hold_bits_i), .pol_inv_i(pol_inv_i), .dir_o(dir_o)
  );

  function automatic bit exp_pin(bit en, bit pol);
    return pol ? en : ~en;
  endfunction

  function automatic bit is_active(bit empty, bit busy);
    return !empty || busy;
  endfunction

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s dir_o=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic model_edge();
    bit a = is_active(txf_empty_i, txsr_busy_i);
    case (m_phase)
      0: if (a) begin m_phase = 1; m_en = 1'b1; end
      1: if (!a) begin
           if (hold_bits_i == 8'd0) begin m_phase = 0; m_en = 1'b0; end
           else begin m_phase = 2; m_left = 16 * int'(hold_bits_i); end
         end
      default: begin
        if (a) m_phase = 1;
        else if (os_tick_i) begin
          m_left--;
          if (m_left == 0) begin m_phase = 0; m_en = 1'b0; end
        end
      end
    endcase
  endtask

  // one clock: edge updates the model, falling edge compares
  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, dir_o, exp_pin(m_en, pol_inv_i));
  endtask

  task automatic drive(bit empty, bit busy, bit tick);
    txf_empty_i = empty; txsr_busy_i = busy; os_tick_i = tick;
  endtask

  // frame then idle with ticks every cycle until released
  task automatic frame_then_hold(int len, int max_idle);
    drive(1'b0, 1'b1, 1'b1); cyc();
    for (int i = 0; i < len; i++) begin drive(1'b1, 1'b1, 1'b1); cyc(); end
    for (int i = 0; i < max_idle && m_en; i++) begin drive(1'b1, 1'b0, 1'b1); cyc(); end
  endtask

  initial begin : watchdog
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int seen;
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0;
    pol_inv_i = 1'b0;
    hold_bits_i = 8'd3;
    drive(1'b1, 1'b0, 1'b0);
    #1;
    tag = "R1";
    check("R1 reset pol0", dir_o, 1'b1);
    pol_inv_i = 1'b1; #1;
    check("R1 reset pol1", dir_o, 1'b0);
    pol_inv_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) cyc();

    // R2: FIFO not empty asserts the enable one edge later
    tag = "R2";
    drive(1'b0, 1'b0, 1'b0); cyc();
    check("R2 fifo asserts", dir_o, 1'b0);
    drive(1'b1, 1'b1, 1'b0); repeat (4) cyc();

    // R4: zero hold
    tag = "R4";
    hold_bits_i = 8'd0;
    drive(1'b1, 1'b0, 1'b0); cyc();
    check("R4 zero hold release", dir_o, 1'b1);

    // R3 / R9: hold of 2 bits, ticks every other cycle
    tag = "R3";
    hold_bits_i = 8'd2;
    drive(1'b0, 1'b1, 1'b1); repeat (3) cyc();
    seen = 0;
    drive(1'b1, 1'b0, 1'b1); cyc(); // hold starts; this tick is ignored (R9)
    tag = "R9";
    for (int i = 0; i < 200 && m_en; i++) begin
      drive(1'b1, 1'b0, i % 2 == 0); cyc();
      if (os_tick_i) seen++;
    end
    tag = "R3";
    check("R3 released", dir_o, 1'b1);
    checks++;
    if (seen != 32) begin
      failures++;
      $display("FAIL R3 ticks to release actual=%0d expected=32", seen);
    end

    // R6: cancel mid-hold, no gap, full restart
    tag = "R6";
    hold_bits_i = 8'd1;
    drive(1'b0, 1'b0, 1'b1); cyc();
    drive(1'b1, 1'b0, 1'b1); repeat (10) cyc();
    drive(1'b0, 1'b0, 1'b1); cyc();
    check("R6 no gap", dir_o, 1'b0);
    drive(1'b1, 1'b0, 1'b1); repeat (16) cyc();
    check("R6 restart full length", dir_o, 1'b0);
    cyc();
    check("R6 released after full length", dir_o, 1'b1);

    // R7: change hold value during a hold
    tag = "R7";
    hold_bits_i = 8'd1;
    drive(1'b0, 1'b0, 1'b0); cyc();
    drive(1'b1, 1'b0, 1'b0); cyc();
    hold_bits_i = 8'd9;
    for (int i = 0; i < 16; i++) begin drive(1'b1, 1'b0, 1'b1); cyc(); end
    check("R7 captured value used", dir_o, 1'b1);

    // R8: polarity flips at once
    tag = "R8";
    pol_inv_i = 1'b1; #1;
    check("R8 idle inverted", dir_o, 1'b0);
    drive(1'b0, 1'b0, 1'b0); cyc();
    check("R8 asserted inverted", dir_o, 1'b1);
    pol_inv_i = 1'b0; #1;
    check("R8 asserted normal", dir_o, 1'b0);
    pol_inv_i = 1'b1;

    // R5: maximum hold
    tag = "R5";
    hold_bits_i = 8'd255;
    frame_then_hold(5, 5000);
    check("R5 max released", dir_o, 1'b0);

    // random mix
    tag = "R6";
    for (int n = 0; n < 30000; n++) begin
      bit e, b, t;
      e = ($urandom % 8) != 0;
      b = ($urandom % 6) == 0;
      t = ($urandom % 3) == 0;
      if (($urandom % 50) == 0) hold_bits_i = 8'($urandom % 4);
      if (($urandom % 400) == 0) pol_inv_i = ~pol_inv_i;
      if (m_phase == 2 && ($urandom % 4) != 0) begin e = 1'b1; b = 1'b0; end
      drive(e, b, t);
      cyc();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule